// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts hardware events and clock cycles so that software can measure how a neighbouring pipeline behaves. It holds four 32-bit event counters and one 32-bit cycle counter. Each event counter is tied to one line of a small event bus through a 7-bit event-type field. The cycle counter advances on every clock, or once every 64 clocks when the divided mode is on. A global enable gates every counter. Each counter also has its own enable bit, and the bits are set and cleared through two separate registers, so several agents can change them without a read-modify-write.

Software reaches the unit through a plain register port: a write strobe, a read strobe, a 4-bit register index and 32-bit data. Event counters are reached indirectly. A select register picks one counter, and two windows then expose that counter's event type and its count. When a counter wraps from all ones to zero, its overflow flag is raised. A flag that also has its interrupt enable set drives the interrupt line until software clears the flag by writing a one to it.

Only the event bus carries data into the block. Each bit is a one-cycle pulse that cannot be stalled, so there is no back-pressure. The register port accepts every access in the cycle it is presented and never waits.

Top module: `pmu_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The control register (index 0) stores only bits 5:0. Bit 0 is the global enable, bit 3 selects divide-by-64 and bits 5:4 are plain storage. Bits 1 and 2 always read as 0. Bits 31:6 read as 0 and ignore writes.
- R3: While control bit 0 is 0, no counter advances, whatever its own enable bit holds.
- R4: Writing control bit 1 as 1 clears all four event counters. Writing control bit 2 as 1 clears the cycle counter and its divider. Each clear takes effect at the edge of that write.
- R5: Writing 1s to the enable-set register (index 1) turns the matching counters on. Writing 1s to the enable-clear register (index 2) turns them off. Zero bits change nothing. Both indices read back the current mask. Bits 3:0 map to event counters 0 to 3 and bit 31 maps to the cycle counter; all other bits read 0.
- R6: An enabled event counter adds one at each clock edge where the event-bus bit numbered by its 7-bit event type (index 6 window) is high. An event type of 8 or more never counts.
- R7: An enabled cycle counter (direct register, index 8) adds one at every edge. With control bit 3 set, it adds one at every 64th edge, counted from its last clear.
- R8: A counter that wraps from all ones to zero sets its flag in the overflow register (index 4), using the same bit mapping as R5. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high while any overflow flag is set together with its bit in the interrupt-enable-set register (index 3). It stays high until that flag is cleared.
- R10: The select register (index 5) holds 5 bits. The type window (index 6) and the count window (index 7) act on event counter `select` when select is 0 to 3. For any other select value, both windows read 0 and ignore writes.
- R11: A write to a counter through its window or its direct register takes priority over an increment in the same cycle.
- R12: A read strobe at a clock edge presents the register's value from before that edge on `reg_rdata`, and the value is held there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_in | input | NUM_EVT | One-cycle event pulses |
| irq | output | 1 | Overflow interrupt, level |

## Verification
A register write takes effect at the edge where its strobe is sampled. Read data appears after the edge of its read strobe, and the scoreboard monitor compares it one nanosecond after that edge. Counter results are exact because every strobe and pulse is driven at a falling edge: a counter that runs for N idle cycles between two control writes gains N+1 counts, and in divided mode the first step falls on the 64th edge after the clear. The bench samples `irq` at a falling edge, so it sees flags and enables one half cycle after the write that changed them.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CTR  = 4;
  localparam int TYPE_W   = 7;
  localparam int SEL_W    = 5;
  localparam int IDX_W    = 4;
  localparam int PRESC_W  = 6;
  localparam int CYC_BIT  = DATA_W - 1;

  typedef enum logic [IDX_W-1:0] {
    RG_CTRL   = 4'd0,
    RG_EN_SET = 4'd1,
    RG_EN_CLR = 4'd2,
    RG_IE_SET = 4'd3,
    RG_OVF    = 4'd4,
    RG_SEL    = 4'd5,
    RG_ETYPE  = 4'd6,
    RG_ECNT   = 4'd7,
    RG_CYC    = 4'd8
  } reg_idx_e;

  // Place per-counter bits into the bus layout: event counters low, cycle counter top.
  function automatic logic [DATA_W-1:0] pack_mask(input logic cyc, input logic [NUM_CTR-1:0] evt);
    logic [DATA_W-1:0] m;
    m = '0;
    m[NUM_CTR-1:0] = evt;
    m[CYC_BIT] = cyc;
    return m;
  endfunction
endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int CNT_W   = 32,
  parameter int TYPE_W  = 7,
  parameter int NUM_EVT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              type_we,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] events,
  output logic [CNT_W-1:0]  count,
  output logic [TYPE_W-1:0] etype,
  output logic              wrap
);
  logic hit;

  // Match the event type against the bus; types beyond the bus never hit.
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (etype == TYPE_W'(k)) hit = events[k];
  end

  logic step;
  assign step = run && hit && !cnt_we && !clr;
  assign wrap = step && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      etype <= '0;
    end else begin
      if (type_we) etype <= wdata[TYPE_W-1:0];
      if (cnt_we)    count <= wdata;
      else if (clr)  count <= '0;
      else if (step) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_mode,
  input  logic             clr,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [PRESC_W-1:0] presc;
  logic tick, step;

  assign tick = div_mode ? (&presc) : 1'b1;
  assign step = run && tick && !we && !clr;
  assign wrap = step && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else begin
      if (clr)                  presc <= '0;
      else if (run && div_mode) presc <= presc + PRESC_W'(1);

      if (we)        count <= wdata;
      else if (clr)  count <= '0;
      else if (step) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  localparam int CNT_W = DATA_W;

  // Control state
  logic              glob_en_q, div_q;
  logic [1:0]        spare_q;
  logic [NUM_CTR-1:0] en_evt_q, ie_evt_q, ovf_evt_q;
  logic              en_cyc_q, ie_cyc_q, ovf_cyc_q;
  logic [SEL_W-1:0]  sel_q;

  // Write decode
  logic wr_ctrl, wr_set, wr_clr, wr_ie, wr_ovf, wr_sel, wr_type, wr_ecnt, wr_cyc;
  assign wr_ctrl = reg_wr && (reg_idx == RG_CTRL);
  assign wr_set  = reg_wr && (reg_idx == RG_EN_SET);
  assign wr_clr  = reg_wr && (reg_idx == RG_EN_CLR);
  assign wr_ie   = reg_wr && (reg_idx == RG_IE_SET);
  assign wr_ovf  = reg_wr && (reg_idx == RG_OVF);
  assign wr_sel  = reg_wr && (reg_idx == RG_SEL);
  assign wr_type = reg_wr && (reg_idx == RG_ETYPE);
  assign wr_ecnt = reg_wr && (reg_idx == RG_ECNT);
  assign wr_cyc  = reg_wr && (reg_idx == RG_CYC);

  logic evt_clr, cyc_clr, sel_ok;
  assign evt_clr = wr_ctrl && reg_wdata[1];
  assign cyc_clr = wr_ctrl && reg_wdata[2];
  assign sel_ok  = sel_q < SEL_W'(NUM_CTR);

  // Event counters
  logic [CNT_W-1:0]  evt_cnt  [NUM_CTR];
  logic [TYPE_W-1:0] evt_type [NUM_CTR];
  logic [NUM_CTR-1:0] evt_wrap;
  logic [NUM_CTR*CNT_W-1:0] evt_flat;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_evt
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q == SEL_W'(i));
    pmu_evt_ctr #(.CNT_W(CNT_W), .TYPE_W(TYPE_W), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (glob_en_q && en_evt_q[i]),
      .clr     (evt_clr),
      .type_we (wr_type && hit_sel),
      .cnt_we  (wr_ecnt && hit_sel),
      .wdata   (reg_wdata),
      .events  (evt_in),
      .count   (evt_cnt[i]),
      .etype   (evt_type[i]),
      .wrap    (evt_wrap[i])
    );
    assign evt_flat[i*CNT_W +: CNT_W] = evt_cnt[i];
  end

  // Cycle counter
  logic [CNT_W-1:0] cyc_cnt;
  logic             cyc_wrap;
  pmu_cyc_ctr #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (glob_en_q && en_cyc_q),
    .div_mode (div_q),
    .clr      (cyc_clr),
    .we       (wr_cyc),
    .wdata    (reg_wdata),
    .count    (cyc_cnt),
    .wrap     (cyc_wrap)
  );

  // Register state updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en_q <= 1'b0;
      div_q     <= 1'b0;
      spare_q   <= '0;
      en_evt_q  <= '0;
      en_cyc_q  <= 1'b0;
      ie_evt_q  <= '0;
      ie_cyc_q  <= 1'b0;
      ovf_evt_q <= '0;
      ovf_cyc_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        glob_en_q <= reg_wdata[0];
        div_q     <= reg_wdata[3];
        spare_q   <= reg_wdata[5:4];
      end
      if (wr_set) begin
        en_evt_q <= en_evt_q | reg_wdata[NUM_CTR-1:0];
        en_cyc_q <= en_cyc_q | reg_wdata[CYC_BIT];
      end else if (wr_clr) begin
        en_evt_q <= en_evt_q & ~reg_wdata[NUM_CTR-1:0];
        en_cyc_q <= en_cyc_q & ~reg_wdata[CYC_BIT];
      end
      if (wr_ie) begin
        ie_evt_q <= ie_evt_q | reg_wdata[NUM_CTR-1:0];
        ie_cyc_q <= ie_cyc_q | reg_wdata[CYC_BIT];
      end
      // A new wrap wins over a clear in the same cycle.
      ovf_evt_q <= (ovf_evt_q & ~({NUM_CTR{wr_ovf}} & reg_wdata[NUM_CTR-1:0])) | evt_wrap;
      ovf_cyc_q <= (ovf_cyc_q & ~(wr_ovf & reg_wdata[CYC_BIT])) | cyc_wrap;
      if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  // Read path
  logic [CNT_W-1:0]  win_cnt;
  logic [TYPE_W-1:0] win_type;
  always_comb begin
    win_cnt  = '0;
    win_type = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (sel_q == SEL_W'(i)) begin
        win_cnt  = evt_cnt[i];
        win_type = evt_type[i];
      end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_idx)
      RG_CTRL:   rd_mux = {{(DATA_W-6){1'b0}}, spare_q, div_q, 2'b00, glob_en_q};
      RG_EN_SET,
      RG_EN_CLR: rd_mux = pack_mask(en_cyc_q, en_evt_q);
      RG_IE_SET: rd_mux = pack_mask(ie_cyc_q, ie_evt_q);
      RG_OVF:    rd_mux = pack_mask(ovf_cyc_q, ovf_evt_q);
      RG_SEL:    rd_mux = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      RG_ETYPE:  rd_mux = {{(DATA_W-TYPE_W){1'b0}}, win_type};
      RG_ECNT:   rd_mux = win_cnt;
      RG_CYC:    rd_mux = cyc_cnt;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq = |({ovf_cyc_q, ovf_evt_q} & {ie_cyc_q, ie_evt_q});
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_wr,
  input logic                      reg_rd,
  input logic [IDX_W-1:0]          reg_idx,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic [DATA_W-1:0]         reg_rdata,
  input logic                      irq,
  input logic                      glob_en,
  input logic                      cyc_en,
  input logic                      div_mode,
  input logic [SEL_W-1:0]          sel,
  input logic [DATA_W-1:0]         cyc_cnt,
  input logic [NUM_CTR*DATA_W-1:0] evt_flat
);
  p_ctrl_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == RG_CTRL) |=> (reg_rdata[2:1] == 2'b00 && reg_rdata[DATA_W-1:6] == '0))
    else $error("R2 control pulse bits read back nonzero");

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !reg_wr) |=> ($stable(cyc_cnt) && $stable(evt_flat)))
    else $error("R3 counter moved while globally disabled");

  p_evt_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == RG_CTRL && reg_wdata[1]) |=> (evt_flat == '0))
    else $error("R4 event counters not cleared");

  p_cyc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && cyc_en && !div_mode && !reg_wr) |=> (cyc_cnt == $past(cyc_cnt) + DATA_W'(1)))
    else $error("R7 cycle counter missed a step");

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_idx == RG_OVF)) |=> irq)
    else $error("R9 interrupt dropped without a flag clear");

  p_sel_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == RG_ECNT && sel >= SEL_W'(NUM_CTR)) |=> (reg_rdata == '0))
    else $error("R10 out-of-range window read nonzero");
endmodule

bind pmu_top pmu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .glob_en   (glob_en_q),
  .cyc_en    (en_cyc_q),
  .div_mode  (div_q),
  .sel       (sel_q),
  .cyc_cnt   (cyc_cnt),
  .evt_flat  (evt_flat)
);

// File: tb/sim_pmu_top.sv
`timescale 1ns/1ps
module sim_pmu_top;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pmu_top #(.NUM_EVT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

  localparam logic [3:0] I_CTRL = 0, I_SET = 1, I_CLR = 2, I_IE = 3, I_OVF = 4,
                         I_SEL = 5, I_TYPE = 6, I_CNT = 7, I_CYC = 8;

  // Driver tasks: called at a falling edge, each occupies exactly one rising edge.
  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_idx = i;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [NE-1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      evt_in = m;
      @(negedge clk);
    end
    evt_in = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  // Monitor: pops the scoreboard one ns after each read edge.
  always @(posedge clk) begin
    if (reg_rd) begin
      #1;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read actual=%h expected=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          failures++;
          $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(I_CTRL, 32'h0, "R1 ctrl");
    rd(I_SET,  32'h0, "R1 enable");
    rd(I_OVF,  32'h0, "R1 overflow");
    rd(I_CYC,  32'h0, "R1 cycle");
    rd(I_SEL,  32'h0, "R1 select");
    chk_irq(1'b0, "R1");

    // R2 control writable bits
    wr(I_CTRL, 32'hFFFF_FFC0);
    rd(I_CTRL, 32'h0, "R2 upper bits ignored");
    wr(I_CTRL, 32'h0000_003E);
    rd(I_CTRL, 32'h0000_0038, "R2 pulses read zero");
    wr(I_CTRL, 32'h0);

    // R5 enable set/clear
    wr(I_SET, 32'hFFFF_FFFF);
    rd(I_SET, 32'h8000_000F, "R5 set mask");
    rd(I_CLR, 32'h8000_000F, "R5 clear reads mask");
    wr(I_CLR, 32'h0000_0002);
    rd(I_SET, 32'h8000_000D, "R5 clear one");
    wr(I_SET, 32'h0);
    rd(I_CLR, 32'h8000_000D, "R5 zero write no change");

    // R6 event types (7 bits)
    wr(I_SEL, 0); wr(I_TYPE, 32'h83);
    rd(I_TYPE, 32'h3, "R6 type width");
    wr(I_SEL, 1); wr(I_TYPE, 5);
    wr(I_SEL, 2); wr(I_TYPE, 32'h40);
    wr(I_SEL, 3); wr(I_TYPE, 3);
    rd(I_TYPE, 32'h3, "R10 window follows select");

    // R6 counting
    wr(I_CTRL, 32'h3);
    pulse(8'h08, 5);
    pulse(8'h20, 3);
    pulse(8'hFF, 2);
    wr(I_SEL, 0); rd(I_CNT, 7, "R6 counter0");
    wr(I_SEL, 1); rd(I_CNT, 0, "R5 disabled counter1");
    wr(I_SEL, 2); rd(I_CNT, 0, "R6 type out of bus");
    wr(I_SEL, 3); rd(I_CNT, 7, "R6 counter3 shares event");
    wr(I_SET, 32'h2);
    pulse(8'h20, 4);
    wr(I_SEL, 1); rd(I_CNT, 4, "R6 counter1 enabled");

    // R3 global gate
    wr(I_CTRL, 0);
    pulse(8'hFF, 3);
    wr(I_SEL, 0); rd(I_CNT, 7, "R3 counter0 held");
    wr(I_SEL, 1); rd(I_CNT, 4, "R3 counter1 held");

    // R4 event clear
    wr(I_CTRL, 32'h2);
    wr(I_SEL, 0); rd(I_CNT, 0, "R4 event counters cleared");

    // R7 and R4 cycle counter
    wr(I_CTRL, 32'h5); idle(9); wr(I_CTRL, 0);
    rd(I_CYC, 10, "R7 every cycle");
    wr(I_CTRL, 32'hD); idle(139); wr(I_CTRL, 32'h8);
    rd(I_CYC, 2, "R7 divide by 64");
    wr(I_CYC, 32'h1234);
    rd(I_CYC, 32'h1234, "R11 direct cycle write");

    // R11 write beats increment
    wr(I_CTRL, 32'h1);
    wr(I_SEL, 0);
    evt_in = 8'h08;
    wr(I_CNT, 100);
    evt_in = '0;
    wr(I_CTRL, 0);
    rd(I_CNT, 100, "R11 write priority");

    // R8/R9 event overflow
    wr(I_CNT, 32'hFFFF_FFFF);
    wr(I_CTRL, 32'h1);
    pulse(8'h08, 1);
    wr(I_CTRL, 0);
    rd(I_CNT, 0, "R8 wrap to zero");
    rd(I_OVF, 32'h1, "R8 flag set");
    chk_irq(1'b0, "R9 not enabled");
    wr(I_IE, 32'h1);
    chk_irq(1'b1, "R9 enabled");
    wr(I_OVF, 32'h0);
    chk_irq(1'b1, "R9 held");
    rd(I_OVF, 32'h1, "R8 zero write keeps flag");
    wr(I_OVF, 32'h1);
    rd(I_OVF, 32'h0, "R8 flag cleared");
    chk_irq(1'b0, "R9 released");

    // R8/R9 cycle overflow
    wr(I_CYC, 32'hFFFF_FFFE);
    wr(I_CTRL, 32'h1); idle(3); wr(I_CTRL, 0);
    rd(I_CYC, 2, "R7 cycle wrap count");
    rd(I_OVF, 32'h8000_0000, "R8 cycle flag bit31");
    chk_irq(1'b0, "R9 cycle not enabled");
    wr(I_IE, 32'h8000_0000);
    chk_irq(1'b1, "R9 cycle enabled");
    wr(I_OVF, 32'h8000_0001);
    rd(I_OVF, 32'h0, "R8 cycle flag cleared");
    chk_irq(1'b0, "R9 cycle released");

    // R10 out-of-range select
    wr(I_SEL, 7);
    rd(I_CNT, 0, "R10 count window zero");
    rd(I_TYPE, 0, "R10 type window zero");
    wr(I_CNT, 55); wr(I_TYPE, 9);
    wr(I_SEL, 0);
    rd(I_CNT, 0, "R10 write ignored count");
    rd(I_TYPE, 3, "R10 write ignored type");
    wr(I_SEL, 32'hFFFF_FFFF);
    rd(I_SEL, 32'h1F, "R10 select width");

    idle(3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule